// File: doc/BRIEF.md
# Floppy Head Seek Sequencer

This block moves the read/write head of a floppy drive to a requested cylinder. It drives the direction and step lines and watches the track-zero sense input. It keeps its own record of the head position, and that record can be in an unknown state. A seek request either moves the head by the distance between the recorded and the requested cylinder, or first drives the head outward until track zero is sensed. It reports the outcome on single-cycle done, fail and reject pulses.

The same request port also switches the drive-select and spindle-motor lines. Switching either line on from off takes a timed wait before done is reported. An inactivity timer turns both lines off after a quiet period. Timing is counted in microsecond ticks from a `us_tick` enable. All programmable delays live in a small register bank that can only be written while the block is idle.

Top module: `fhs_seek_seq`

## Requirements
- R1: Each step sets `step_dir` (0 = outward, 1 = inward), waits SETUP_US µs, raises `step_pulse` for PULSE_US µs, lowers it, then waits the step interval. A step is followed by one decision cycle before the next step's direction setup. With `us_tick` high every cycle, a delay of N ≥ 1 µs lasts exactly N clock cycles, so the pulse is 10 cycles wide and rising edges are (step interval + 21) cycles apart.
- R2: A seek (op 0) to a cylinder when the position is known and the target is not 0 issues |target − current| steps in the right direction. It then waits the settle time and pulses `done`, and `cur_cyl` shows the target. `done` follows the last falling edge of `step_pulse` by step interval + settle + 1 cycles.
- R3: A seek to cylinder 0, or any seek while the position is unknown, first steps outward until `trk0_n` reads low, with at most 256 steps. No steps are issued if `trk0_n` is already low. The block then records cylinder 0 and continues as in R2. When a recalibration is the last motion, done comes one cycle later than in R2.
- R4: If `trk0_n` is still high after 256 recalibration steps, `fail` pulses, `cyl_known` goes low, and no settle wait is applied.
- R5: A seek to a cylinder above MAX_CYL (85), a select or motor request with an argument above 1, or op 3 makes `reject` pulse in the cycle after the request. Nothing moves, `busy` stays low and `cur_cyl` keeps its value.
- R6: `busy` is high from the cycle after a seek or a delayed switch request is accepted, until the cycle in which `done` or `fail` pulses. Requests made while `busy` is high are ignored and produce no response.
- R7: A select request (op 1, arg 1) while `drv_sel` is low raises `drv_sel` and pulses `done` after the select delay, 1 + delay cycles after the request cycle. Turning it off, or turning it on when it is already on, pulses `done` in the cycle after the request.
- R8: A motor request (op 2) behaves like R7 on `motor_on`, using the motor delay.
- R9: When the idle-timeout delay passes with no busy state and no new request, `drv_sel` and `motor_on` both go low. Every request reloads the timer.
- R10: Writing a delay register (`cfg_addr` 0 step interval, 1 settle, 2 select, 3 motor, 4 idle timeout) takes effect for later operations only when `busy` is low. Writes while busy are dropped.
- R11: After reset, outputs are low and `cyl_known` is 0. The delays are 3000 µs step interval, 15000 µs settle, 10 µs select, 750000 µs motor and 10000000 µs idle timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle enable per microsecond |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 seek, 1 select, 2 motor, 3 invalid |
| req_arg | input | CYL_W | Target cylinder, or on/off level in bit 0 |
| cfg_we | input | 1 | Delay register write strobe |
| cfg_addr | input | 3 | Delay register index |
| cfg_data | input | DLY_W | Delay value in microseconds |
| trk0_n | input | 1 | Low when the head is at track zero |
| step_dir | output | 1 | Step direction, 1 = inward |
| step_pulse | output | 1 | Step strobe |
| drv_sel | output | 1 | Drive select line |
| motor_on | output | 1 | Spindle motor line |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle track-zero failure pulse |
| reject | output | 1 | One-cycle bad-request pulse |
| cur_cyl | output | CYL_W | Recorded cylinder |
| cyl_known | output | 1 | Recorded cylinder is valid |

## Verification
The seek function is tried with several kinds of move: inward moves, outward moves, moves of zero distance, a long move to the highest cylinder, an out-of-range target, and recalibrations that start at track zero, at a distance, or from an unknown position. Together these separate a wrong step count, a wrong direction, and a recalibration that is wrongly skipped or wrongly forced. A drive model whose track-zero line never falls checks the 256-step limit. Cycle-exact spacing of the step edges and of the done pulse checks the programmed delays, and it also shows whether a register write made while busy was wrongly accepted.

// File: rtl/fhs_pkg.sv
// Shared types and encodings for the floppy head seek sequencer.
// Assumes: the request op field is two bits, and the delay index is three bits.
package fhs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_SETUP, ST_PULSE, ST_GAP, ST_SETTLE, ST_SEL, ST_MOT
    } fhs_state_e;

    localparam logic [1:0] OP_SEEK = 2'd0;
    localparam logic [1:0] OP_SEL  = 2'd1;
    localparam logic [1:0] OP_MOT  = 2'd2;

    localparam int NUM_DLY  = 5;
    localparam int DI_STEP  = 0;
    localparam int DI_SETTLE = 1;
    localparam int DI_SEL   = 2;
    localparam int DI_MOT   = 3;
    localparam int DI_IDLE  = 4;
endpackage

// File: rtl/fhs_delay.sv
// Microsecond delay counter. A start loads the count. When tick is high every
// cycle, expired rises in the Nth cycle after the load, for N >= 1.
// Assumes: start is only asserted on a state transition of the owner.
module fhs_delay #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load on start, otherwise count down once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (start)               cnt <= load_val;
        else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0) || (cnt == W'(1) && tick);
endmodule

// File: rtl/fhs_idle.sv
// Inactivity timer. While arm is high it reloads and stays armed. Once arm
// has been low for the loaded number of ticks, it pulses expire and disarms.
// Assumes: arm is high whenever the owner is busy or receives a request.
module fhs_idle #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         arm,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic         armed;
    logic [W-1:0] cnt;

    assign expire = armed && !arm && ((cnt == '0) || (cnt == W'(1) && tick));

    // Reload on arm, disarm on expiry, otherwise count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            cnt   <= load_val;
        end else if (expire) begin
            armed <= 1'b0;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    p_expire_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
endmodule

// File: rtl/fhs_cfg.sv
// Bank of programmable delay registers, each reset to its default.
// Assumes: writes are only honoured while the sequencer is not busy.
module fhs_cfg #(
    parameter int W          = 24,
    parameter int DEF_STEP   = 3000,
    parameter int DEF_SETTLE = 15000,
    parameter int DEF_SEL    = 10,
    parameter int DEF_MOT    = 750000,
    parameter int DEF_IDLE   = 10000000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy,
    input  logic         we,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dly [fhs_pkg::NUM_DLY]
);
    localparam int DEFS [fhs_pkg::NUM_DLY] = '{DEF_STEP, DEF_SETTLE, DEF_SEL, DEF_MOT, DEF_IDLE};

    for (genvar i = 0; i < fhs_pkg::NUM_DLY; i++) begin : g_reg
        // One delay register: default on reset, write only while idle.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  dly[i] <= W'(DEFS[i]);
            else if (we && !busy && addr == 3'(i))       dly[i] <= wdata;
        end

        p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
            busy |=> $stable(dly[i]));
    end
endmodule

// File: rtl/fhs_seek_seq.sv
// Floppy head seek sequencer top. It runs the step/recalibrate/settle state
// machine and the select and motor handshakes, and owns the cylinder record.
// Assumes: trk0_n is already synchronised, and us_tick is one cycle per us.
module fhs_seek_seq #(
    parameter int CYL_W      = 8,
    parameter int MAX_CYL    = 85,
    parameter int RECAL_MAX  = 256,
    parameter int DLY_W      = 24,
    parameter int SETUP_US   = 10,
    parameter int PULSE_US   = 10,
    parameter int DEF_STEP   = 3000,
    parameter int DEF_SETTLE = 15000,
    parameter int DEF_SEL    = 10,
    parameter int DEF_MOT    = 750000,
    parameter int DEF_IDLE   = 10000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [CYL_W-1:0] req_arg,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [DLY_W-1:0] cfg_data,
    input  logic             trk0_n,
    output logic             step_dir,
    output logic             step_pulse,
    output logic             drv_sel,
    output logic             motor_on,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             reject,
    output logic [CYL_W-1:0] cur_cyl,
    output logic             cyl_known
);
    import fhs_pkg::*;

    localparam int RC_W = $clog2(RECAL_MAX + 1);

    fhs_state_e       state, nxt;
    logic             recal;
    logic [RC_W-1:0]  rcnt;
    logic [CYL_W-1:0] tgt;
    logic             t_start, t_exp, idle_exp, idle_arm;
    logic [DLY_W-1:0] t_val;
    logic [DLY_W-1:0] dly [NUM_DLY];
    logic             seek_ok, lvl_ok, sel_wait, mot_wait;

    assign busy     = (state != ST_IDLE);
    assign seek_ok  = (req_arg <= CYL_W'(MAX_CYL));
    assign lvl_ok   = (req_arg <= CYL_W'(1));
    assign sel_wait = lvl_ok && req_arg[0] && !drv_sel;
    assign mot_wait = lvl_ok && req_arg[0] && !motor_on;
    assign idle_arm = busy || req_valid;

    fhs_cfg #(.W(DLY_W), .DEF_STEP(DEF_STEP), .DEF_SETTLE(DEF_SETTLE),
              .DEF_SEL(DEF_SEL), .DEF_MOT(DEF_MOT), .DEF_IDLE(DEF_IDLE)) cfg_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .we(cfg_we),
        .addr(cfg_addr), .wdata(cfg_data), .dly(dly));

    fhs_delay #(.W(DLY_W)) dly_i (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .start(t_start),
        .load_val(t_val), .expired(t_exp));

    fhs_idle #(.W(DLY_W)) idle_i (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .arm(idle_arm),
        .load_val(dly[DI_IDLE]), .expire(idle_exp));

    // Next state and delay-timer load selection.
    always_comb begin
        nxt     = state;
        t_start = 1'b0;
        t_val   = '0;
        case (state)
            ST_IDLE: if (req_valid) begin
                if (req_op == OP_SEEK && seek_ok) nxt = ST_CHECK;
                else if (req_op == OP_SEL && sel_wait) begin
                    nxt = ST_SEL; t_start = 1'b1; t_val = dly[DI_SEL];
                end else if (req_op == OP_MOT && mot_wait) begin
                    nxt = ST_MOT; t_start = 1'b1; t_val = dly[DI_MOT];
                end
            end
            ST_CHECK: begin
                if (recal) begin
                    if (trk0_n && rcnt == RC_W'(RECAL_MAX)) nxt = ST_IDLE;
                    else if (trk0_n) begin
                        nxt = ST_SETUP; t_start = 1'b1; t_val = DLY_W'(SETUP_US);
                    end
                end else if (cur_cyl == tgt) begin
                    nxt = ST_SETTLE; t_start = 1'b1; t_val = dly[DI_SETTLE];
                end else begin
                    nxt = ST_SETUP; t_start = 1'b1; t_val = DLY_W'(SETUP_US);
                end
            end
            ST_SETUP: if (t_exp) begin
                nxt = ST_PULSE; t_start = 1'b1; t_val = DLY_W'(PULSE_US);
            end
            ST_PULSE: if (t_exp) begin
                nxt = ST_GAP; t_start = 1'b1; t_val = dly[DI_STEP];
            end
            ST_GAP:    if (t_exp) nxt = ST_CHECK;
            ST_SETTLE, ST_SEL, ST_MOT: if (t_exp) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State, outputs and cylinder record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; recal <= 1'b0; rcnt <= '0; tgt <= '0;
            step_dir <= 1'b0; step_pulse <= 1'b0; drv_sel <= 1'b0; motor_on <= 1'b0;
            done <= 1'b0; fail <= 1'b0; reject <= 1'b0;
            cur_cyl <= '0; cyl_known <= 1'b0;
        end else begin
            state  <= nxt;
            done   <= 1'b0;
            fail   <= 1'b0;
            reject <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (idle_exp) begin
                        drv_sel  <= 1'b0;
                        motor_on <= 1'b0;
                    end
                    if (req_valid) begin
                        case (req_op)
                            OP_SEEK: if (seek_ok) begin
                                tgt   <= req_arg;
                                recal <= (req_arg == '0) || !cyl_known;
                                rcnt  <= '0;
                            end else reject <= 1'b1;
                            OP_SEL: if (!lvl_ok) reject <= 1'b1;
                                    else begin drv_sel <= req_arg[0]; done <= !sel_wait; end
                            OP_MOT: if (!lvl_ok) reject <= 1'b1;
                                    else begin motor_on <= req_arg[0]; done <= !mot_wait; end
                            default: reject <= 1'b1;
                        endcase
                    end
                end
                ST_CHECK: begin
                    if (recal) begin
                        if (!trk0_n) begin
                            recal <= 1'b0; cur_cyl <= '0; cyl_known <= 1'b1;
                        end else if (rcnt == RC_W'(RECAL_MAX)) begin
                            cyl_known <= 1'b0; fail <= 1'b1;
                        end else begin
                            step_dir <= 1'b0; rcnt <= rcnt + 1'b1;
                        end
                    end else if (cur_cyl != tgt) begin
                        step_dir <= (tgt > cur_cyl);
                    end
                end
                ST_SETUP: if (t_exp) step_pulse <= 1'b1;
                ST_PULSE: if (t_exp) step_pulse <= 1'b0;
                ST_GAP:   if (t_exp && !recal)
                              cur_cyl <= step_dir ? cur_cyl + 1'b1 : cur_cyl - 1'b1;
                ST_SETTLE, ST_SEL, ST_MOT: if (t_exp) done <= 1'b1;
                default: ;
            endcase
        end
    end

    p_dir_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> $stable(step_dir));
    p_step_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> busy);
    p_known_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cyl_known |-> (cur_cyl <= CYL_W'(MAX_CYL)));
    p_recal_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rcnt <= RC_W'(RECAL_MAX));
    p_fail_unknown_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !cyl_known);
    p_one_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail, reject}));
    p_reject_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !busy);
    p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_exp |=> (!drv_sel && !motor_on));
endmodule

// File: tb/fhs_seek_seq_tb_top.sv
module fhs_seek_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [7:0] req_arg = '0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [23:0] cfg_data = '0;
    logic       trk0_n;
    logic       step_dir, step_pulse, drv_sel, motor_on, busy, done, fail, reject, cyl_known;
    logic [7:0] cur_cyl;

    int  head = 2;
    bit  trk_broken = 1'b0;
    int  cyc = 0;
    int  n_tot = 0, n_bad = 0;
    int  n_in, n_out, n_done, n_fail, n_rej;
    int  last_rise, prev_rise, last_fall, t_resp, t_req;
    bit  step_q = 1'b0;

    localparam int STEP = 5, SETTLE = 20, SEL = 7, MOT = 30, IDLE = 300;
    localparam int NV = 7;
    localparam int TV_CYL [NV] = '{10, 3, 3, 85, 86, 0, 0};
    localparam int TV_RES [NV] = '{0, 0, 0, 0, 2, 0, 0};
    localparam int TV_IN  [NV] = '{10, 0, 0, 82, 0, 0, 0};
    localparam int TV_OUT [NV] = '{0, 7, 0, 0, 0, 85, 0};
    localparam int TV_CUR [NV] = '{10, 3, 3, 85, 85, 0, 0};

    assign trk0_n = trk_broken || (head != 0);

    always #10 clk = ~clk;

    fhs_seek_seq dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(1'b1), .req_valid(req_valid),
        .req_op(req_op), .req_arg(req_arg), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .trk0_n(trk0_n), .step_dir(step_dir),
        .step_pulse(step_pulse), .drv_sel(drv_sel), .motor_on(motor_on),
        .busy(busy), .done(done), .fail(fail), .reject(reject),
        .cur_cyl(cur_cyl), .cyl_known(cyl_known));

    always @(posedge clk) cyc <= cyc + 1;

    // Drive model and response monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (step_pulse && !step_q) begin
            if (step_dir) begin n_in++; head++; end
            else begin n_out++; if (head > 0) head--; end
            prev_rise = last_rise;
            last_rise = cyc;
        end
        if (!step_pulse && step_q) last_fall = cyc;
        step_q = step_pulse;
        if (done)   begin n_done++; t_resp = cyc; end
        if (fail)   begin n_fail++; t_resp = cyc; end
        if (reject) begin n_rej++;  t_resp = cyc; end
    end

    // Global watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_tot++; n_bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 190000);
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic clr();
        n_in = 0; n_out = 0; n_done = 0; n_fail = 0; n_rej = 0;
        last_rise = 0; prev_rise = 0; last_fall = 0; t_resp = 0;
    endtask

    task automatic pulse_req(input logic [1:0] op, input int arg);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_arg = 8'(arg); t_req = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_resp();
        for (int i = 0; i < 40000; i++) begin
            if (n_done + n_fail + n_rej > 0) return;
            @(negedge clk);
        end
        chk(1'b0, "response timeout", 0, 1);
    endtask

    task automatic cmd(input logic [1:0] op, input int arg);
        clr();
        pulse_req(op, arg);
        wait_resp();
        @(negedge clk);
    endtask

    task automatic wcfg(input int a, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_data = 24'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state.
        chk(!busy && !step_pulse && !step_dir && !drv_sel && !motor_on && !done,
            "R11 outputs low in reset", {busy, step_pulse, drv_sel, motor_on}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cyl_known && !busy, "R11 position unknown after reset", cyl_known, 0);

        // R11/R3: default delays, recalibration from cylinder 2.
        cmd(fhs_pkg::OP_SEEK, 0);
        chk(n_out == 2 && n_in == 0, "R3 recal step count", n_out, 2);
        chk(last_rise - prev_rise == 3021, "R11 default step interval", last_rise - prev_rise, 3021);
        chk(t_resp - last_fall == 18002, "R11 default settle", t_resp - last_fall, 18002);
        chk(cyl_known && cur_cyl == 0, "R3 cylinder zero recorded", cur_cyl, 0);

        wcfg(fhs_pkg::DI_STEP, STEP);
        wcfg(fhs_pkg::DI_SETTLE, SETTLE);
        wcfg(fhs_pkg::DI_SEL, SEL);
        wcfg(fhs_pkg::DI_MOT, MOT);
        wcfg(fhs_pkg::DI_IDLE, IDLE);

        // R1 R2 R3 R5: table of seeks.
        for (int v = 0; v < NV; v++) begin
            cmd(fhs_pkg::OP_SEEK, TV_CYL[v]);
            chk(n_in == TV_IN[v], "R2 inward steps", n_in, TV_IN[v]);
            chk(n_out == TV_OUT[v], "R3 outward steps", n_out, TV_OUT[v]);
            chk(int'(cur_cyl) == TV_CUR[v] && cyl_known, "R2 recorded cylinder", cur_cyl, TV_CUR[v]);
            if (TV_RES[v] == 2) begin
                chk(n_rej == 1 && n_done == 0, "R5 reject pulse", n_rej, 1);
                chk(t_resp - t_req == 1, "R5 reject latency", t_resp - t_req, 1);
            end else begin
                chk(n_done == 1 && n_fail == 0, "R2 done pulse", n_done, 1);
            end
            if (TV_IN[v] + TV_OUT[v] >= 2) begin
                chk(last_rise - prev_rise == STEP + 21, "R1 step period", last_rise - prev_rise, STEP + 21);
                chk(last_fall - last_rise == 10, "R1 pulse width", last_fall - last_rise, 10);
                chk(t_resp - last_fall == STEP + SETTLE + 1 + (TV_CYL[v] == 0 ? 1 : 0),
                    "R2 settle latency", t_resp - last_fall, STEP + SETTLE + 1 + (TV_CYL[v] == 0 ? 1 : 0));
            end
        end

        // R6 R10: requests and delay writes during busy are ignored.
        clr();
        pulse_req(fhs_pkg::OP_SEEK, 20);
        repeat (3) @(negedge clk);
        chk(busy, "R6 busy during seek", busy, 1);
        pulse_req(fhs_pkg::OP_SEEK, 2);
        wcfg(fhs_pkg::DI_STEP, 40);
        wait_resp();
        repeat (60) @(negedge clk);
        chk(n_in == 20 && n_out == 0 && cur_cyl == 20, "R6 busy request ignored", cur_cyl, 20);
        chk(n_done == 1 && !busy, "R6 single response", n_done, 1);
        cmd(fhs_pkg::OP_SEEK, 22);
        chk(last_rise - prev_rise == STEP + 21, "R10 busy write dropped", last_rise - prev_rise, STEP + 21);
        wcfg(fhs_pkg::DI_STEP, 9);
        cmd(fhs_pkg::OP_SEEK, 24);
        chk(last_rise - prev_rise == 30, "R10 idle write applied", last_rise - prev_rise, 30);
        wcfg(fhs_pkg::DI_STEP, STEP);

        // R4: track zero never seen.
        trk_broken = 1'b1;
        cmd(fhs_pkg::OP_SEEK, 0);
        chk(n_fail == 1 && n_done == 0, "R4 fail pulse", n_fail, 1);
        chk(n_out == 256, "R4 step limit", n_out, 256);
        chk(!cyl_known, "R4 position unknown", cyl_known, 0);

        // R3: unknown position forces recal before an inward seek.
        trk_broken = 1'b0;
        head = 3;
        cmd(fhs_pkg::OP_SEEK, 4);
        chk(n_out == 3 && n_in == 4 && n_done == 1, "R3 recal when unknown", n_out * 10 + n_in, 34);
        chk(cyl_known && cur_cyl == 4, "R3 cylinder after recal", cur_cyl, 4);

        // R7 R8 R5: select and motor handshakes.
        cmd(fhs_pkg::OP_SEL, 1);
        chk(drv_sel && t_resp - t_req == SEL + 1, "R7 select on delay", t_resp - t_req, SEL + 1);
        cmd(fhs_pkg::OP_SEL, 1);
        chk(drv_sel && t_resp - t_req == 1, "R7 select already on", t_resp - t_req, 1);
        cmd(fhs_pkg::OP_SEL, 0);
        chk(!drv_sel && t_resp - t_req == 1, "R7 select off", t_resp - t_req, 1);
        cmd(fhs_pkg::OP_SEL, 1);
        chk(drv_sel && t_resp - t_req == SEL + 1, "R7 select on again", t_resp - t_req, SEL + 1);
        cmd(fhs_pkg::OP_MOT, 1);
        chk(motor_on && t_resp - t_req == MOT + 1, "R8 motor on delay", t_resp - t_req, MOT + 1);
        cmd(fhs_pkg::OP_MOT, 1);
        chk(motor_on && t_resp - t_req == 1, "R8 motor already on", t_resp - t_req, 1);
        cmd(fhs_pkg::OP_SEL, 2);
        chk(n_rej == 1 && drv_sel && t_resp - t_req == 1, "R5 bad level rejected", n_rej, 1);
        cmd(2'd3, 0);
        chk(n_rej == 1 && n_done == 0, "R5 invalid op rejected", n_rej, 1);

        // R9: inactivity timeout and re-arm.
        repeat (200) @(negedge clk);
        chk(drv_sel && motor_on, "R9 lines held before timeout", {drv_sel, motor_on}, 3);
        cmd(fhs_pkg::OP_MOT, 1);
        repeat (250) @(negedge clk);
        chk(drv_sel && motor_on, "R9 request re-arms timer", {drv_sel, motor_on}, 3);
        repeat (100) @(negedge clk);
        chk(!drv_sel && !motor_on, "R9 lines off after timeout", {drv_sel, motor_on}, 0);

        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule